// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block keeps the request, mask and in-service state for eight interrupt lines of a single interrupt controller. Each line is captured as either level-sensitive or edge-sensitive, which is chosen per line. A combinational search then finds the best unmasked pending line. The search starts at a programmable three-bit rotation base and walks upward, wrapping around. The block raises a registered interrupt request only when that line ranks strictly ahead of every line already in service.

A processor-side agent acknowledges the request through a single-cycle port. In the same cycle, the port returns the winning line number with a valid flag. At the next clock edge it commits the bookkeeping:

- The winning line is either marked in service or, in automatic end-of-interrupt mode, optionally used to rotate the base.
- An edge-sensitive line has its pending flag dropped.

Software-facing writes of the mask and base, and a clear of one in-service bit by line number, are presented as simple strobes by the surrounding logic. The block can also be built as the master of a cascade. In that case a special nested mode removes the cascade line's in-service bit from the priority comparison.

Top module: `irq_rank_unit`

## Requirements
- R1: For a line whose trigger-select bit is 1 (level), the pending bit after a clock edge equals the line's input value sampled at that edge.
- R2: For a line whose trigger-select bit is 0 (edge), the pending bit becomes 1 when the input is 1 at an edge after being 0 at the previous edge. A 0 input only updates the remembered level and leaves the pending bit unchanged.
- R3: Candidates are pending bits whose mask bit is 0. With no candidate, the interrupt request stays 0 and an acknowledge returns valid 0.
- R4: Rank r corresponds to line (r + base) mod 8, and the candidate with the smallest rank wins.
- R5: The request is raised only when the winner's rank is strictly smaller than the smallest rank held by any in-service bit. Equal rank does not qualify.
- R6: When the unit is built as master and special nested mode is 1, the in-service bit of the cascade line (line 2) is ignored in the in-service rank.
- R7: An acknowledge with a winner and automatic end-of-interrupt off sets the winner's in-service bit at the next edge.
- R8: With automatic end-of-interrupt on, an acknowledge leaves the in-service bits unchanged. If rotate-on-automatic-EOI is also on, the base becomes (winner + 1) mod 8.
- R9: An acknowledge clears the winner's pending bit only if the line is edge-triggered. A level-triggered winner stays pending.
- R10: The interrupt request output is a register: it reflects the pending, mask, in-service and base state one clock edge after that state changes.
- R11: An acknowledge with no winner returns valid 0 and changes no pending, in-service or base state.
- R12: The in-service clear strobe clears exactly the in-service bit of the given line number.
- R13: After reset, pending, remembered level, mask, in-service, base and request output are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqLines | input | NUM_LINES | Raw interrupt inputs |
| trigLevel | input | NUM_LINES | Per-line trigger select, 1 = level, 0 = edge |
| specialNested | input | 1 | Ignore the cascade line's in-service bit (master build only) |
| autoEoi | input | 1 | Automatic end-of-interrupt on acknowledge |
| rotateOnAutoEoi | input | 1 | Rotate base on automatic end-of-interrupt |
| maskWrEn | input | 1 | Load mask register |
| maskWrData | input | NUM_LINES | New mask value, 1 = masked |
| baseWrEn | input | 1 | Load rotation base |
| baseWrData | input | IDX_W | New rotation base |
| isrClrEn | input | 1 | Clear one in-service bit |
| isrClrLine | input | IDX_W | Line whose in-service bit is cleared |
| ackReq | input | 1 | Acknowledge strobe |
| irqOut | output | 1 | Registered interrupt request |
| ackValid | output | 1 | Acknowledge found a winner |
| ackLine | output | IDX_W | Winning line number |
| pendingOut | output | NUM_LINES | Pending register |
| inServiceOut | output | NUM_LINES | In-service register |
| maskOut | output | NUM_LINES | Mask register |
| baseOut | output | IDX_W | Rotation base |

## Verification
The bench builds the unit with eight lines, as master, with the cascade line at 2. This makes the special nested exclusion reachable alongside every wrap-around of the rotating rank search. Probing the acknowledge port combinationally, without committing, lets one pending pattern be ranked under several bases. Equal-rank, masked and cascade-line cases are driven so that the strict comparison and the exclusion each decide an outcome.

// File: rtl/irq_rank_pkg.sv
package irq_rank_pkg;
  // strobes from control to datapath for one acknowledge
  typedef struct packed {
    logic take;     // acknowledge accepted with a winner
    logic setIsr;   // mark winner in service
    logic rotate;   // move base past the winner
    logic clrPend;  // drop winner pending bit (edge lines)
  } ackStrobe_t;
endpackage

// File: rtl/irq_rank_dp.sv
module irq_rank_dp
  import irq_rank_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic [NUM_LINES-1:0] trigLevel,
  input  logic                 maskWrEn,
  input  logic [NUM_LINES-1:0] maskWrData,
  input  logic                 baseWrEn,
  input  logic [IDX_W-1:0]     baseWrData,
  input  logic                 isrClrEn,
  input  logic [IDX_W-1:0]     isrClrLine,
  input  ackStrobe_t           strobes,
  input  logic [IDX_W-1:0]     ackLine,
  input  logic                 reqHit,
  output logic [NUM_LINES-1:0] candVec,
  output logic [NUM_LINES-1:0] pendVec,
  output logic [NUM_LINES-1:0] isrVec,
  output logic [NUM_LINES-1:0] maskVec,
  output logic [IDX_W-1:0]     baseVal,
  output logic                 irqOut
);

  logic [NUM_LINES-1:0] pendQ, lastQ, maskQ, isrQ;
  logic [NUM_LINES-1:0] pendNext, isrNext;
  logic [IDX_W-1:0]     baseQ, baseNext;
  logic                 irqQ;
  logic                 pastValid;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      if (trigLevel[i]) pendNext[i] = irqLines[i];
      else              pendNext[i] = pendQ[i] | (irqLines[i] & ~lastQ[i]);
    end
    if (strobes.clrPend) pendNext[ackLine] = 1'b0;
  end

  always_comb begin
    isrNext = isrQ;
    if (isrClrEn)       isrNext[isrClrLine] = 1'b0;
    if (strobes.setIsr) isrNext[ackLine] = 1'b1;
  end

  always_comb begin
    baseNext = baseQ;
    if (strobes.rotate)  baseNext = IDX_W'(ackLine + 1'b1);
    else if (baseWrEn)   baseNext = baseWrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendQ     <= '0;
      lastQ     <= '0;
      maskQ     <= '0;
      isrQ      <= '0;
      baseQ     <= '0;
      irqQ      <= 1'b0;
      pastValid <= 1'b0;
    end else begin
      pendQ     <= pendNext;
      lastQ     <= irqLines;
      isrQ      <= isrNext;
      baseQ     <= baseNext;
      irqQ      <= reqHit;
      pastValid <= 1'b1;
      if (maskWrEn) maskQ <= maskWrData;
    end
  end

  assign candVec = pendQ & ~maskQ;
  assign pendVec = pendQ;
  assign isrVec  = isrQ;
  assign maskVec = maskQ;
  assign baseVal = baseQ;
  assign irqOut  = irqQ;

  for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_lineChk
    // R1: level line pending tracks sampled input
    p_level_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pastValid && $past(trigLevel[gi]) |-> pendQ[gi] == $past(irqLines[gi]));
    // R2: low input on an edge line never alters pending unless acknowledged
    p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pastValid && $past(!trigLevel[gi] && !irqLines[gi] &&
                         !(strobes.clrPend && ackLine == IDX_W'(gi)))
      |-> pendQ[gi] == $past(pendQ[gi]));
  end

  // R7: accepted acknowledge marks the winner in service
  p_isr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.setIsr |=> isrQ[$past(ackLine)]);

  // R7: at most one in-service bit appears per edge
  p_isr_one_new_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pastValid |-> $countones(isrQ & ~$past(isrQ)) <= 1);

  // R8: rotation lands just past the acknowledged line
  p_rotate_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.rotate |=> baseQ == IDX_W'($past(ackLine) + 1'b1));

  // R11: refused acknowledge with no other writes leaves in-service intact
  p_noack_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pastValid && $past(!strobes.take && !isrClrEn) |-> isrQ == $past(isrQ));

endmodule

// File: rtl/irq_rank_ctrl.sv
module irq_rank_ctrl
  import irq_rank_pkg::*;
#(
  parameter int NUM_LINES    = 8,
  parameter bit IS_MASTER    = 1'b1,
  parameter int CASCADE_LINE = 2,
  localparam int IDX_W  = $clog2(NUM_LINES),
  localparam int RANK_W = IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] candVec,
  input  logic [NUM_LINES-1:0] isrVec,
  input  logic [IDX_W-1:0]     baseVal,
  input  logic [NUM_LINES-1:0] trigLevel,
  input  logic                 specialNested,
  input  logic                 autoEoi,
  input  logic                 rotateOnAutoEoi,
  input  logic                 ackReq,
  output logic                 reqHit,
  output logic                 ackValid,
  output logic [IDX_W-1:0]     ackLine,
  output ackStrobe_t           strobes
);

  // smallest rank whose line is set; NUM_LINES when none
  function automatic logic [RANK_W-1:0] rankOf(input logic [NUM_LINES-1:0] v,
                                               input logic [IDX_W-1:0] b);
    logic [RANK_W-1:0] r;
    r = RANK_W'(NUM_LINES);
    for (int k = NUM_LINES - 1; k >= 0; k--) begin
      logic [IDX_W-1:0] idx;
      idx = IDX_W'(k) + b;
      if (v[idx]) r = RANK_W'(k);
    end
    return r;
  endfunction

  logic [NUM_LINES-1:0] isrEff;
  logic [RANK_W-1:0]    winRank, curRank;
  logic [IDX_W-1:0]     winLine;

  if (IS_MASTER) begin : g_master
    always_comb begin
      isrEff = isrVec;
      if (specialNested) isrEff[CASCADE_LINE] = 1'b0;
    end
  end else begin : g_slave
    assign isrEff = isrVec;
  end

  assign winRank = rankOf(candVec, baseVal);
  assign curRank = rankOf(isrEff, baseVal);
  assign winLine = IDX_W'(winRank[IDX_W-1:0] + baseVal);
  assign reqHit  = (winRank != RANK_W'(NUM_LINES)) && (winRank < curRank);

  assign ackValid = ackReq && reqHit;
  assign ackLine  = winLine;

  always_comb begin
    strobes.take    = ackValid;
    strobes.setIsr  = ackValid && !autoEoi;
    strobes.rotate  = ackValid && autoEoi && rotateOnAutoEoi;
    strobes.clrPend = ackValid && !trigLevel[winLine];
  end

  // R4: acknowledged line is always an unmasked pending line
  p_ack_is_cand_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ackValid |-> candVec[ackLine]);

  // R5: a line already in service cannot win, except the excluded cascade line
  p_ack_not_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ackValid && !(IS_MASTER && specialNested && ackLine == IDX_W'(CASCADE_LINE))
    |-> !isrVec[ackLine]);

endmodule

// File: rtl/irq_rank_unit.sv
module irq_rank_unit
  import irq_rank_pkg::*;
#(
  parameter int NUM_LINES    = 8,
  parameter bit IS_MASTER    = 1'b1,
  parameter int CASCADE_LINE = 2,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic [NUM_LINES-1:0] trigLevel,
  input  logic                 specialNested,
  input  logic                 autoEoi,
  input  logic                 rotateOnAutoEoi,
  input  logic                 maskWrEn,
  input  logic [NUM_LINES-1:0] maskWrData,
  input  logic                 baseWrEn,
  input  logic [IDX_W-1:0]     baseWrData,
  input  logic                 isrClrEn,
  input  logic [IDX_W-1:0]     isrClrLine,
  input  logic                 ackReq,
  output logic                 irqOut,
  output logic                 ackValid,
  output logic [IDX_W-1:0]     ackLine,
  output logic [NUM_LINES-1:0] pendingOut,
  output logic [NUM_LINES-1:0] inServiceOut,
  output logic [NUM_LINES-1:0] maskOut,
  output logic [IDX_W-1:0]     baseOut
);

  ackStrobe_t           strobes;
  logic [NUM_LINES-1:0] candVec, isrVec;
  logic [IDX_W-1:0]     baseVal;
  logic                 reqHit;

  irq_rank_ctrl #(
    .NUM_LINES(NUM_LINES), .IS_MASTER(IS_MASTER), .CASCADE_LINE(CASCADE_LINE)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .candVec(candVec), .isrVec(isrVec), .baseVal(baseVal),
    .trigLevel(trigLevel), .specialNested(specialNested),
    .autoEoi(autoEoi), .rotateOnAutoEoi(rotateOnAutoEoi),
    .ackReq(ackReq), .reqHit(reqHit), .ackValid(ackValid),
    .ackLine(ackLine), .strobes(strobes)
  );

  irq_rank_dp #(.NUM_LINES(NUM_LINES)) dp_i (
    .clk(clk), .rst_n(rst_n),
    .irqLines(irqLines), .trigLevel(trigLevel),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .isrClrEn(isrClrEn), .isrClrLine(isrClrLine),
    .strobes(strobes), .ackLine(ackLine), .reqHit(reqHit),
    .candVec(candVec), .pendVec(pendingOut), .isrVec(isrVec),
    .maskVec(maskOut), .baseVal(baseVal), .irqOut(irqOut)
  );

  assign inServiceOut = isrVec;
  assign baseOut      = baseVal;

endmodule

// File: tb/irq_rank_unit_tb_top.sv
`timescale 1ns/1ps
module irq_rank_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irqLines, trigLevel, maskWrData;
  logic       specialNested, autoEoi, rotateOnAutoEoi;
  logic       maskWrEn, baseWrEn, isrClrEn, ackReq;
  logic [2:0] baseWrData, isrClrLine;
  logic       irqOut, ackValid;
  logic [2:0] ackLine, baseOut;
  logic [7:0] pendingOut, inServiceOut, maskOut;

  int nChecks = 0;
  int nFails  = 0;
  logic pkValid;
  logic [2:0] pkLine;

  always #4 clk = ~clk;

  irq_rank_unit dut_i (
    .clk(clk), .rst_n(rst_n), .irqLines(irqLines), .trigLevel(trigLevel),
    .specialNested(specialNested), .autoEoi(autoEoi),
    .rotateOnAutoEoi(rotateOnAutoEoi), .maskWrEn(maskWrEn),
    .maskWrData(maskWrData), .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .isrClrEn(isrClrEn), .isrClrLine(isrClrLine), .ackReq(ackReq),
    .irqOut(irqOut), .ackValid(ackValid), .ackLine(ackLine),
    .pendingOut(pendingOut), .inServiceOut(inServiceOut),
    .maskOut(maskOut), .baseOut(baseOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rst_n = 1'b0; irqLines = '0; trigLevel = '0; maskWrData = '0;
    specialNested = 1'b0; autoEoi = 1'b0; rotateOnAutoEoi = 1'b0;
    maskWrEn = 1'b0; baseWrEn = 1'b0; isrClrEn = 1'b0; ackReq = 1'b0;
    baseWrData = '0; isrClrLine = '0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic pulse(input int ln);
    irqLines[ln] = 1'b1; step(1);
    irqLines[ln] = 1'b0; step(1);
  endtask

  task automatic peek();
    ackReq = 1'b1; #1;
    pkValid = ackValid; pkLine = ackLine;
    ackReq = 1'b0;
  endtask

  task automatic doAck();
    ackReq = 1'b1; #1;
    pkValid = ackValid; pkLine = ackLine;
    step(1);
    ackReq = 1'b0;
  endtask

  task automatic setBase(input int b);
    baseWrEn = 1'b1; baseWrData = 3'(b); step(1); baseWrEn = 1'b0;
  endtask

  task automatic t_reset();
    doReset();
    chk("R13 irqOut", irqOut, 0);
    chk("R13 pending", pendingOut, 0);
    chk("R13 inService", inServiceOut, 0);
    chk("R13 mask", maskOut, 0);
    chk("R13 base", baseOut, 0);
  endtask

  task automatic t_level();
    doReset();
    trigLevel[5] = 1'b1; irqLines[5] = 1'b1; step(1);
    chk("R1 level high pending", pendingOut, 8'h20);
    irqLines[5] = 1'b0; step(1);
    chk("R1 level low pending", pendingOut, 8'h00);
  endtask

  task automatic t_edge();
    doReset();
    irqLines[3] = 1'b1; step(1);
    chk("R2 rise sets", pendingOut, 8'h08);
    step(1);
    chk("R2 held high keeps", pendingOut, 8'h08);
    irqLines[3] = 1'b0; step(1);
    chk("R2 low keeps pending", pendingOut, 8'h08);
  endtask

  task automatic t_lag();
    doReset();
    irqLines[4] = 1'b1; step(1);
    chk("R10 pending first edge", pendingOut, 8'h10);
    chk("R10 irq not yet", irqOut, 0);
    step(1);
    chk("R10 irq next edge", irqOut, 1);
  endtask

  task automatic t_maskNoAck();
    doReset();
    maskWrEn = 1'b1; maskWrData = 8'h10; step(1); maskWrEn = 1'b0;
    pulse(4); step(1);
    chk("R3 masked irq low", irqOut, 0);
    doAck();
    chk("R11 ack refused", pkValid, 0);
    chk("R11 pending kept", pendingOut, 8'h10);
    chk("R11 inService kept", inServiceOut, 0);
    chk("R11 base kept", baseOut, 0);
  endtask

  task automatic t_rotate();
    doReset();
    pulse(1); pulse(6);
    chk("R4 irq raised", irqOut, 1);
    peek(); chk("R4 base0 winner", pkLine, 1);
    setBase(5); peek(); chk("R4 base5 winner", pkLine, 6);
    setBase(2); peek(); chk("R4 base2 winner", pkLine, 6);
    setBase(7); peek(); chk("R4 base7 winner", pkLine, 1);
    chk("R4 peek no commit", pendingOut, 8'h42);
  endtask

  task automatic t_nest();
    doReset();
    pulse(1);
    doAck();
    chk("R7 ack valid", pkValid, 1);
    chk("R7 inService set", inServiceOut, 8'h02);
    chk("R9 edge pending cleared", pendingOut, 8'h00);
    pulse(1); step(1);
    chk("R5 equal rank blocked", irqOut, 0);
    pulse(3); step(1);
    chk("R5 lower rank blocked", irqOut, 0);
    peek(); chk("R5 ack refused", pkValid, 0);
    pulse(0); step(1);
    chk("R5 higher rank raised", irqOut, 1);
    peek(); chk("R5 higher winner", pkLine, 0);
    isrClrEn = 1'b1; isrClrLine = 3'd1; step(1); isrClrEn = 1'b0;
    chk("R12 specific clear", inServiceOut, 8'h00);
  endtask

  task automatic t_levelAck();
    doReset();
    trigLevel[5] = 1'b1; irqLines[5] = 1'b1; step(2);
    doAck();
    chk("R9 level ack line", pkLine, 5);
    chk("R9 level stays pending", pendingOut, 8'h20);
    chk("R7 level in service", inServiceOut, 8'h20);
  endtask

  task automatic t_sfnm();
    doReset();
    pulse(2); doAck();
    chk("R6 cascade in service", inServiceOut, 8'h04);
    pulse(2); step(1);
    chk("R6 nested off blocked", irqOut, 0);
    specialNested = 1'b1; step(2);
    chk("R6 nested on raised", irqOut, 1);
    peek(); chk("R6 nested winner", pkLine, 2);
    specialNested = 1'b0;
  endtask

  task automatic t_aeoi();
    doReset();
    autoEoi = 1'b1;
    pulse(3); doAck();
    chk("R8 aeoi line", pkLine, 3);
    chk("R8 aeoi no inService", inServiceOut, 0);
    chk("R8 aeoi base kept", baseOut, 0);
    rotateOnAutoEoi = 1'b1;
    pulse(6); doAck();
    chk("R8 rotate base", baseOut, 7);
    chk("R8 rotate no inService", inServiceOut, 0);
    pulse(6); pulse(0);
    peek(); chk("R8 rotated winner", pkLine, 0);
  endtask

  initial begin
    t_reset();
    t_level();
    t_edge();
    t_lag();
    t_maskNoAck();
    t_rotate();
    t_nest();
    t_levelAck();
    t_sfnm();
    t_aeoi();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule